// File: doc/BRIEF.md
# Dual-Digitizer Acquisition Controller

This block runs the capture of a waveform each time a low-threshold discriminator rises. It stamps the event with the value of a free-running time counter, counts it, fires a launch strobe at one of two waveform digitizer units and, when enabled, a coincidence strobe to neighbouring stations. It then waits for that unit to report completion and streams the chosen channel into a waveform buffer.

The two digitizer units are used in strict alternation. While one unit is still being digitized or read out, a new trigger can launch the other, so a second pulse arriving close behind the first is not lost. Only when both units are occupied is a trigger dropped, and the dropped triggers are counted. The readout channel follows from the discriminator levels: a pulse that crossed only the low threshold is read from the high-gain channel, and a pulse that also crossed the high threshold is read from the middle channel. Any channel found saturated is followed by the next lower-gain channel. A single-photoelectron mode launches only on every Nth qualifying pulse and marks those events in the status word.

A timeout guards the wait for each unit. Each finished event, whether read normally or aborted, produces one status word with its timestamp.

Top module: `dual_digitizer_acq`

## Requirements
- R1: The cycle after a rising edge of `disc_lo` is sampled on a clock edge, exactly one bit of `launch_stb` is high for one cycle, and `evt_count` has advanced by one. If `coinc_en` was high at that edge, `coinc_stb` is high for one cycle in the following cycle; otherwise it stays low. Holding `disc_lo` high does not start another event.
- R2: The first channel read is 0 when `disc_hi` was low at the triggering edge and 1 when it was high.
- R3: If any sample of the channel being read has `dig_sat` high, and that channel is not 2, the next higher-numbered (lower-gain) channel is read after it; this repeats, so channel 0 can be followed by 1 and then by 2.
- R4: Launches alternate between unit 0 and unit 1, beginning with unit 0 after reset. A unit's `unit_busy` bit is high from the cycle after its launch until its status word appears, and units are read out in launch order.
- R5: A trigger arriving while both units are busy launches nothing, leaves `evt_count` unchanged and increments `dead_count` by one.
- R6: With `spe_mode` high, qualifying edges are counted. Only the edge that brings the count to `spe_thresh` (with a threshold of 0 or 1, every edge) launches an event. That event carries the single-photoelectron flag, and the count restarts from zero. Lowering `spe_mode` clears the count.
- R7: Each channel read writes `NSAMP` consecutive words into the buffer, with `buf_wdata` equal to `dig_data` for the unit, channel and sample shown on `rd_unit`, `rd_chan` and `rd_sample`. `buf_addr` counts from 0 across all channels of one event. The status word follows the last write.
- R8: `status_word` is valid for the one cycle in which `status_vld` is high, with this layout: bit 0 is the unit; bits 2:1 are the last channel read; bit 3 is the OR of saturation over all channels read; bit 4 is the coincidence flag; bit 5 is the single-photoelectron flag; bit 6 is the timeout error; bits 8:7 are the first channel chosen.
- R9: `status_time` equals the value of `tick_cnt` on the clock edge where the triggering edge of `disc_lo` was detected.
- R10: If the unit being waited on does not raise its `dig_done` bit within `TMO_CYC` cycles, the event ends with no buffer writes and with status bit 6 set, and the unit is freed.
- R11: After reset, all strobes, `buf_we` and `status_vld` are low, and both counters and `unit_busy` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disc_lo | input | 1 | Low-threshold discriminator level |
| disc_hi | input | 1 | High-threshold discriminator level |
| coinc_en | input | 1 | Enables the coincidence strobe and flag for new events |
| spe_mode | input | 1 | Single-photoelectron prescale mode |
| spe_thresh | input | SPE_W | Number of qualifying edges per launch in that mode |
| tick_cnt | input | TS_W | Free-running time counter |
| dig_done | input | 2 | Per-unit digitization-complete flags |
| dig_sat | input | 1 | Saturation flag for the sample being read |
| dig_data | input | DATA_W | Sample returned for rd_unit/rd_chan/rd_sample |
| launch_stb | output | 2 | One-cycle launch strobe per unit |
| coinc_stb | output | 1 | One-cycle coincidence strobe |
| rd_sel_stb | output | 1 | Strobe marking the selection of a new channel to read |
| rd_unit | output | 1 | Unit being read |
| rd_chan | output | 2 | Channel being read |
| rd_sample | output | SMP_W | Sample index being read |
| buf_we | output | 1 | Waveform buffer write enable |
| buf_addr | output | AW | Waveform buffer word address |
| buf_wdata | output | DATA_W | Waveform buffer write data |
| status_vld | output | 1 | Status word valid |
| status_word | output | 9 | Event status, layout in R8 |
| status_time | output | TS_W | Event timestamp |
| evt_count | output | EVT_W | Launched event count |
| dead_count | output | EVT_W | Dropped trigger count |
| unit_busy | output | 2 | Per-unit busy flags |

## Verification
The main function is exercised by sweeping both discriminator levels, the coincidence enable and all eight per-channel saturation patterns. This separates the choice of starting channel from the length and order of the fallback chain, including the case where channel 2 saturates and nothing follows. Pairs and triples of closely spaced pulses against a slow digitizer distinguish alternation between the units from the dead-time drop. Prescale runs at two thresholds show which edges launch and confirm the counter restart. A digitizer that never answers exercises the timeout path.

// File: rtl/acq_pkg.sv
package acq_pkg;

  localparam int NUNIT = 2;
  localparam int NCHAN = 3;
  localparam int CH_W  = 2;

  // Per-event tag held with each digitizer unit while it is busy.
  typedef struct packed {
    logic [CH_W-1:0] first_ch;
    logic            spe;
    logic            coinc;
  } unit_tag_t;

  // Status word, MSB first: [8:7] first, [6] err, [5] spe, [4] coinc,
  // [3] sat, [2:1] last channel, [0] unit.
  typedef struct packed {
    logic [CH_W-1:0] first_ch;
    logic            err;
    logic            spe;
    logic            coinc;
    logic            sat;
    logic [CH_W-1:0] last_ch;
    logic            unit;
  } acq_status_t;

  localparam int ST_W = $bits(acq_status_t);

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_WAIT,
    RD_SEL,
    RD_READ,
    RD_DONE
  } rd_state_e;

endpackage

// File: rtl/acq_rst_sync.sv
module acq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/acq_trigger.sv
module acq_trigger
  import acq_pkg::*;
#(
  parameter int TS_W  = 48,
  parameter int EVT_W = 16,
  parameter int SPE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disc_lo,
  input  logic             disc_hi,
  input  logic             coinc_en,
  input  logic             spe_mode,
  input  logic [SPE_W-1:0] spe_thresh,
  input  logic [TS_W-1:0]  tick_cnt,
  input  logic             rel_valid,
  input  logic             rel_unit,
  input  logic             sel_idx,
  output unit_tag_t        sel_tag,
  output logic [TS_W-1:0]  sel_time,
  output logic [NUNIT-1:0] busy,
  output logic [NUNIT-1:0] launch_stb,
  output logic             coinc_stb,
  output logic [EVT_W-1:0] evt_count,
  output logic [EVT_W-1:0] dead_count
);

  logic             disc_q;
  logic [NUNIT-1:0] busy_q, busy_d;
  logic             wr_ptr_q, wr_ptr_d;
  logic [NUNIT-1:0] launch_q, launch_d;
  logic             arm_q, arm_d;
  logic             coinc_q, coinc_d;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic [EVT_W-1:0] dead_q, dead_d;
  logic [SPE_W-1:0] spe_cnt_q, spe_cnt_d;

  unit_tag_t        tag_q  [NUNIT];
  logic [TS_W-1:0]  time_q [NUNIT];
  unit_tag_t        new_tag;

  logic edge_seen, full, drop, spe_hit, go;

  // Edge detect and launch decision.
  assign edge_seen = disc_lo & ~disc_q;
  assign full      = busy_q[wr_ptr_q];
  assign drop      = edge_seen & full;
  assign spe_hit   = (({1'b0, spe_cnt_q} + (SPE_W+1)'(1)) >= {1'b0, spe_thresh});
  assign go        = edge_seen & ~full & (~spe_mode | spe_hit);

  always_comb begin
    new_tag.first_ch = disc_hi ? CH_W'(1) : CH_W'(0);
    new_tag.spe      = spe_mode;
    new_tag.coinc    = coinc_en;
  end

  always_comb begin
    busy_d    = busy_q;
    wr_ptr_d  = wr_ptr_q;
    launch_d  = '0;
    arm_d     = go & coinc_en;
    coinc_d   = arm_q;
    evt_d     = evt_q;
    dead_d    = dead_q;
    spe_cnt_d = spe_cnt_q;
    if (rel_valid) busy_d[rel_unit] = 1'b0;
    if (go) begin
      busy_d[wr_ptr_q] = 1'b1;
      wr_ptr_d         = ~wr_ptr_q;
      launch_d         = NUNIT'(1) << wr_ptr_q;
      evt_d            = evt_q + EVT_W'(1);
    end
    if (drop) dead_d = dead_q + EVT_W'(1);
    if (!spe_mode)                  spe_cnt_d = '0;
    else if (edge_seen && !full)    spe_cnt_d = spe_hit ? '0 : spe_cnt_q + SPE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disc_q    <= 1'b0;
      busy_q    <= '0;
      wr_ptr_q  <= 1'b0;
      launch_q  <= '0;
      arm_q     <= 1'b0;
      coinc_q   <= 1'b0;
      evt_q     <= '0;
      dead_q    <= '0;
      spe_cnt_q <= '0;
    end else begin
      disc_q    <= disc_lo;
      busy_q    <= busy_d;
      wr_ptr_q  <= wr_ptr_d;
      launch_q  <= launch_d;
      arm_q     <= arm_d;
      coinc_q   <= coinc_d;
      evt_q     <= evt_d;
      dead_q    <= dead_d;
      spe_cnt_q <= spe_cnt_d;
    end
  end

  // Per-unit event tag and timestamp, loaded on launch into that unit.
  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic load;
    assign load = go && (wr_ptr_q == 1'(u));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[u]  <= '0;
        time_q[u] <= '0;
      end else if (load) begin
        tag_q[u]  <= new_tag;
        time_q[u] <= tick_cnt;
      end
    end
  end

  assign sel_tag    = tag_q[sel_idx];
  assign sel_time   = time_q[sel_idx];
  assign busy       = busy_q;
  assign launch_stb = launch_q;
  assign coinc_stb  = coinc_q;
  assign evt_count  = evt_q;
  assign dead_count = dead_q;

  // R5
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (&busy_q));

  // R1
  coinc_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_q |-> $past(|launch_q));

  // R4
  launch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_q));

  // R4
  launch_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|launch_q) |-> ((launch_q & busy_q) == launch_q));

endmodule

// File: rtl/acq_readout.sv
module acq_readout
  import acq_pkg::*;
#(
  parameter int TS_W    = 48,
  parameter int DATA_W  = 10,
  parameter int NSAMP   = 8,
  parameter int TMO_CYC = 1024,
  localparam int SMP_W  = (NSAMP > 1) ? $clog2(NSAMP) : 1,
  localparam int AW     = $clog2(NSAMP * NCHAN),
  localparam int TMO_W  = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUNIT-1:0]  busy,
  input  unit_tag_t         tag_in,
  input  logic [TS_W-1:0]   time_in,
  output logic              rd_ptr,
  input  logic [NUNIT-1:0]  dig_done,
  input  logic              dig_sat,
  input  logic [DATA_W-1:0] dig_data,
  output logic              rd_sel_stb,
  output logic              rd_unit,
  output logic [CH_W-1:0]   rd_chan,
  output logic [SMP_W-1:0]  rd_sample,
  output logic              buf_we,
  output logic [AW-1:0]     buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              rel_valid,
  output logic              rel_unit,
  output logic              status_vld,
  output logic [ST_W-1:0]   status_word,
  output logic [TS_W-1:0]   status_time
);

  rd_state_e        st_q, st_d;
  logic             ptr_q, ptr_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             cur_sat_q, cur_sat_d;
  logic             any_sat_q, any_sat_d;
  logic             err_q, err_d;

  acq_status_t      st_word_d;
  logic [ST_W-1:0]  st_word_q;
  logic [TS_W-1:0]  st_time_q;
  logic             st_vld_q;

  logic last_smp, chan_sat;

  assign last_smp = (smp_q == SMP_W'(NSAMP - 1));
  assign chan_sat = cur_sat_q | dig_sat;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    chan_d    = chan_q;
    smp_d     = smp_q;
    addr_d    = addr_q;
    tmo_d     = tmo_q;
    cur_sat_d = cur_sat_q;
    any_sat_d = any_sat_q;
    err_d     = err_q;
    unique case (st_q)
      RD_IDLE: begin
        tmo_d = '0;
        err_d = 1'b0;
        if (busy[ptr_q]) st_d = RD_WAIT;
      end
      RD_WAIT: begin
        if (dig_done[ptr_q]) begin
          st_d      = RD_SEL;
          chan_d    = tag_in.first_ch;
          addr_d    = '0;
          any_sat_d = 1'b0;
        end else if (tmo_q == TMO_W'(TMO_CYC - 1)) begin
          st_d      = RD_DONE;
          err_d     = 1'b1;
          chan_d    = tag_in.first_ch;
          any_sat_d = 1'b0;
        end else begin
          tmo_d = tmo_q + TMO_W'(1);
        end
      end
      RD_SEL: begin
        smp_d     = '0;
        cur_sat_d = 1'b0;
        st_d      = RD_READ;
      end
      RD_READ: begin
        smp_d     = smp_q + SMP_W'(1);
        addr_d    = addr_q + AW'(1);
        cur_sat_d = chan_sat;
        any_sat_d = any_sat_q | dig_sat;
        if (last_smp) begin
          if (chan_sat && (chan_q != CH_W'(NCHAN - 1))) begin
            chan_d = chan_q + CH_W'(1);
            st_d   = RD_SEL;
          end else begin
            st_d = RD_DONE;
          end
        end
      end
      RD_DONE: begin
        ptr_d = ~ptr_q;
        st_d  = RD_IDLE;
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_comb begin
    st_word_d.unit     = ptr_q;
    st_word_d.last_ch  = chan_q;
    st_word_d.sat      = any_sat_q;
    st_word_d.coinc    = tag_in.coinc;
    st_word_d.spe      = tag_in.spe;
    st_word_d.err      = err_q;
    st_word_d.first_ch = tag_in.first_ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RD_IDLE;
      ptr_q     <= 1'b0;
      chan_q    <= '0;
      smp_q     <= '0;
      addr_q    <= '0;
      tmo_q     <= '0;
      cur_sat_q <= 1'b0;
      any_sat_q <= 1'b0;
      err_q     <= 1'b0;
      st_vld_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      ptr_q     <= ptr_d;
      chan_q    <= chan_d;
      smp_q     <= smp_d;
      addr_q    <= addr_d;
      tmo_q     <= tmo_d;
      cur_sat_q <= cur_sat_d;
      any_sat_q <= any_sat_d;
      err_q     <= err_d;
      st_vld_q  <= (st_q == RD_DONE);
    end
  end

  // Status payload registers, loaded only when an event completes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_word_q <= '0;
      st_time_q <= '0;
    end else if (st_q == RD_DONE) begin
      st_word_q <= st_word_d;
      st_time_q <= time_in;
    end
  end

  assign rd_ptr      = ptr_q;
  assign rd_sel_stb  = (st_q == RD_SEL);
  assign rd_unit     = ptr_q;
  assign rd_chan     = chan_q;
  assign rd_sample   = smp_q;
  assign buf_we      = (st_q == RD_READ);
  assign buf_addr    = addr_q;
  assign buf_wdata   = dig_data;
  assign rel_valid   = (st_q == RD_DONE);
  assign rel_unit    = ptr_q;
  assign status_vld  = st_vld_q;
  assign status_word = st_word_q;
  assign status_time = st_time_q;

  // R3
  fallback_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_SEL && $past(st_q) == RD_READ) |-> (chan_q == $past(chan_q) + CH_W'(1)));

  // R10
  timeout_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_DONE && err_q) |-> ($past(st_q) == RD_WAIT));

  // R7
  buf_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (int'(addr_q) < NSAMP * NCHAN));

  // R4
  release_busy_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> busy[ptr_q]);

endmodule

// File: rtl/dual_digitizer_acq.sv
module dual_digitizer_acq
  import acq_pkg::*;
#(
  parameter int TS_W    = 48,
  parameter int EVT_W   = 16,
  parameter int SPE_W   = 8,
  parameter int DATA_W  = 10,
  parameter int NSAMP   = 8,
  parameter int TMO_CYC = 1024,
  localparam int SMP_W  = (NSAMP > 1) ? $clog2(NSAMP) : 1,
  localparam int AW     = $clog2(NSAMP * NCHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disc_lo,
  input  logic              disc_hi,
  input  logic              coinc_en,
  input  logic              spe_mode,
  input  logic [SPE_W-1:0]  spe_thresh,
  input  logic [TS_W-1:0]   tick_cnt,
  input  logic [1:0]        dig_done,
  input  logic              dig_sat,
  input  logic [DATA_W-1:0] dig_data,
  output logic [1:0]        launch_stb,
  output logic              coinc_stb,
  output logic              rd_sel_stb,
  output logic              rd_unit,
  output logic [1:0]        rd_chan,
  output logic [SMP_W-1:0]  rd_sample,
  output logic              buf_we,
  output logic [AW-1:0]     buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              status_vld,
  output logic [8:0]        status_word,
  output logic [TS_W-1:0]   status_time,
  output logic [EVT_W-1:0]  evt_count,
  output logic [EVT_W-1:0]  dead_count,
  output logic [1:0]        unit_busy
);

  logic            rst_sync_n;
  logic            rel_valid, rel_unit, rd_ptr;
  unit_tag_t       sel_tag;
  logic [TS_W-1:0] sel_time;

  acq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acq_trigger #(
    .TS_W  (TS_W),
    .EVT_W (EVT_W),
    .SPE_W (SPE_W)
  ) u_trig (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .disc_lo    (disc_lo),
    .disc_hi    (disc_hi),
    .coinc_en   (coinc_en),
    .spe_mode   (spe_mode),
    .spe_thresh (spe_thresh),
    .tick_cnt   (tick_cnt),
    .rel_valid  (rel_valid),
    .rel_unit   (rel_unit),
    .sel_idx    (rd_ptr),
    .sel_tag    (sel_tag),
    .sel_time   (sel_time),
    .busy       (unit_busy),
    .launch_stb (launch_stb),
    .coinc_stb  (coinc_stb),
    .evt_count  (evt_count),
    .dead_count (dead_count)
  );

  acq_readout #(
    .TS_W    (TS_W),
    .DATA_W  (DATA_W),
    .NSAMP   (NSAMP),
    .TMO_CYC (TMO_CYC)
  ) u_rd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .busy        (unit_busy),
    .tag_in      (sel_tag),
    .time_in     (sel_time),
    .rd_ptr      (rd_ptr),
    .dig_done    (dig_done),
    .dig_sat     (dig_sat),
    .dig_data    (dig_data),
    .rd_sel_stb  (rd_sel_stb),
    .rd_unit     (rd_unit),
    .rd_chan     (rd_chan),
    .rd_sample   (rd_sample),
    .buf_we      (buf_we),
    .buf_addr    (buf_addr),
    .buf_wdata   (buf_wdata),
    .rel_valid   (rel_valid),
    .rel_unit    (rel_unit),
    .status_vld  (status_vld),
    .status_word (status_word),
    .status_time (status_time)
  );

endmodule

// File: tb/tb_dual_digitizer_acq.sv
`timescale 1ns/1ps
module tb_dual_digitizer_acq;

  localparam int NS  = 8;
  localparam int TMO = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disc_lo = 1'b0, disc_hi = 1'b0, coinc_en = 1'b0, spe_mode = 1'b0;
  logic [7:0]  spe_thresh = 8'd0;
  logic [47:0] tick_cnt = 48'hFFFF_FFFF_F000;
  logic [1:0]  dig_done;
  logic        dig_sat;
  logic [9:0]  dig_data;
  logic [1:0]  launch_stb;
  logic        coinc_stb, rd_sel_stb, rd_unit;
  logic [1:0]  rd_chan;
  logic [2:0]  rd_sample;
  logic        buf_we;
  logic [4:0]  buf_addr;
  logic [9:0]  buf_wdata;
  logic        status_vld;
  logic [8:0]  status_word;
  logic [47:0] status_time;
  logic [15:0] evt_count, dead_count;
  logic [1:0]  unit_busy;

  dual_digitizer_acq dut (.*);

  always #2 clk = ~clk;
  always @(negedge clk) tick_cnt <= tick_cnt + 48'd1;

  // Digitizer responder model.
  int  dlat = 12;
  bit  done_block = 1'b0;
  int  dcnt [2] = '{1000, 1000};
  logic [2:0] sat_cfg = 3'b000;

  always @(posedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (launch_stb[u]) dcnt[u] <= 0;
      else if (dcnt[u] < 100000) dcnt[u] <= dcnt[u] + 1;
    end
  end

  function automatic logic [9:0] smp(input int u, input int c, input int s);
    return {u[0], c[1:0], 7'(s * 9 + c * 3 + 1)};
  endfunction

  assign dig_done[0] = !done_block && (dcnt[0] >= dlat);
  assign dig_done[1] = !done_block && (dcnt[1] >= dlat);
  assign dig_data    = smp(int'(rd_unit), int'(rd_chan), int'(rd_sample));
  assign dig_sat     = (rd_sample == 3'd3) && sat_cfg[rd_chan];

  // Buffer write capture.
  int wcount = 0;
  int waddr [64];
  logic [9:0] wdata [64];
  always @(negedge clk) begin
    if (buf_we && wcount < 64) begin
      waddr[wcount] <= int'(buf_addr);
      wdata[wcount] <= buf_wdata;
      wcount <= wcount + 1;
    end
  end

  int nvec = 0, nerr = 0;
  int exp_ptr = 0;
  int exp_evt = 0;
  int exp_dead = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Raise disc_lo; check launch and coincidence timing.
  task automatic fire(input bit hi, input bit go, input bit hold, output longint t, output int unit);
    @(negedge clk); #1;
    disc_hi = hi; disc_lo = 1'b1; t = longint'(tick_cnt);
    unit = exp_ptr;
    @(negedge clk);
    if (go) begin
      exp_evt++;
      chk(launch_stb == (2'b01 << exp_ptr), "R4", "launch unit", launch_stb, 2'b01 << exp_ptr);
      chk(unit_busy[exp_ptr] == 1'b1, "R4", "busy after launch", unit_busy[exp_ptr], 1);
      exp_ptr ^= 1;
    end else begin
      chk(launch_stb == 2'b00, "R5", "no launch", launch_stb, 0);
    end
    chk(int'(evt_count) == exp_evt, "R1", "event count", evt_count, exp_evt);
    chk(int'(dead_count) == exp_dead, "R5", "dead count", dead_count, exp_dead);
    @(negedge clk);
    chk(coinc_stb == (go & coinc_en), "R1", "coinc strobe", coinc_stb, go & coinc_en);
    chk(launch_stb == 2'b00, "R1", "single launch", launch_stb, 0);
    if (hold) begin
      repeat (3) @(negedge clk);
      chk(launch_stb == 2'b00, "R1", "held level no retrigger", launch_stb, 0);
    end
    #1 disc_lo = 1'b0; disc_hi = 1'b0;
  endtask

  // Wait for a status word and compare it with the computed event.
  task automatic expect_event(input int unit, input bit hi, input bit cen, input bit spe,
                              input longint t);
    int chans [3];
    int nch = 0, ch, w;
    bit anys = 1'b0;
    w = 0;
    while (!status_vld && w < 3000) begin @(negedge clk); w++; end
    chk(status_vld == 1'b1, "R7", "status arrived", status_vld, 1);
    ch = hi ? 1 : 0;
    forever begin
      chans[nch] = ch; nch++;
      if (!sat_cfg[ch]) break;
      anys = 1'b1;
      if (ch == 2) break;
      ch++;
    end
    chk(wcount == nch * NS, "R7", "write count", wcount, nch * NS);
    for (int i = 0; i < nch * NS && i < wcount; i++) begin
      chk(waddr[i] == i, "R7", "buffer addr", waddr[i], i);
      chk(wdata[i] == smp(unit, chans[i / NS], i % NS), "R3", "buffer data",
          wdata[i], smp(unit, chans[i / NS], i % NS));
    end
    chk(status_word[0] == unit[0], "R4", "status unit", status_word[0], unit);
    chk(int'(status_word[8:7]) == (hi ? 1 : 0), "R2", "first chan", status_word[8:7], hi);
    chk(int'(status_word[2:1]) == chans[nch-1], "R3", "last chan", status_word[2:1], chans[nch-1]);
    chk(status_word[3] == anys, "R8", "sat flag", status_word[3], anys);
    chk(status_word[4] == cen, "R8", "coinc flag", status_word[4], cen);
    chk(status_word[5] == spe, "R6", "spe flag", status_word[5], spe);
    chk(status_word[6] == 1'b0, "R8", "err flag", status_word[6], 0);
    chk(longint'(status_time) == t, "R9", "timestamp", status_time, t);
    chk(unit_busy[unit] == 1'b0, "R4", "unit freed", unit_busy[unit], 0);
    wcount = 0;
    @(negedge clk);
    chk(status_vld == 1'b0, "R8", "status one cycle", status_vld, 0);
  endtask

  initial begin
    longint ta, tb, tc;
    int ua, ub, uc, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(launch_stb == 0 && coinc_stb == 0, "R11", "strobes idle", {launch_stb, coinc_stb}, 0);
    chk(buf_we == 0 && status_vld == 0, "R11", "buffer/status idle", {buf_we, status_vld}, 0);
    chk(evt_count == 0 && dead_count == 0, "R11", "counters", {evt_count, dead_count}, 0);
    chk(unit_busy == 0, "R11", "busy", unit_busy, 0);

    // R2 R3 R8 sweep over levels, coincidence and saturation patterns.
    for (int hi = 0; hi < 2; hi++)
      for (int ce = 0; ce < 2; ce++)
        for (int s = 0; s < 8; s++) begin
          sat_cfg = 3'(s); coinc_en = ce[0];
          fire(hi[0], 1'b1, (s == 5), ta, ua);
          expect_event(ua, hi[0], ce[0], 1'b0, ta);
        end

    // R5 dead time with a slow digitizer.
    sat_cfg = 3'b000; coinc_en = 1'b1; dlat = 80;
    fire(1'b0, 1'b1, 1'b0, ta, ua);
    fire(1'b1, 1'b1, 1'b0, tb, ub);
    chk(unit_busy == 2'b11, "R4", "both busy", unit_busy, 3);
    exp_dead++;
    fire(1'b0, 1'b0, 1'b0, tc, uc);
    expect_event(ua, 1'b0, 1'b1, 1'b0, ta);
    expect_event(ub, 1'b1, 1'b1, 1'b0, tb);
    dlat = 12;

    // R6 prescale with threshold 3, then 1.
    spe_mode = 1'b1; spe_thresh = 8'd3; coinc_en = 1'b0; sat_cfg = 3'b010;
    for (int k = 1; k <= 6; k++) begin
      fire(k[0], (k % 3 == 0), 1'b0, ta, ua);
      if (k % 3 == 0) expect_event(ua, k[0], 1'b0, 1'b1, ta);
      else repeat (30) @(negedge clk);
      chk(status_vld == 1'b0 && wcount == 0, "R6", "no stray event", wcount, 0);
    end
    fire(1'b0, 1'b0, 1'b0, ta, ua);          // count now 1
    spe_mode = 1'b0; @(negedge clk);          // clears count
    spe_mode = 1'b1; spe_thresh = 8'd2;
    fire(1'b0, 1'b0, 1'b0, ta, ua);          // count restarts: 1 of 2
    fire(1'b1, 1'b1, 1'b0, ta, ua);
    expect_event(ua, 1'b1, 1'b0, 1'b1, ta);
    spe_thresh = 8'd1;
    fire(1'b0, 1'b1, 1'b0, ta, ua);
    expect_event(ua, 1'b0, 1'b0, 1'b1, ta);
    spe_mode = 1'b0;

    // R10 timeout with a silent digitizer.
    done_block = 1'b1; sat_cfg = 3'b000;
    fire(1'b1, 1'b1, 1'b0, ta, ua);
    w = 0;
    while (!status_vld && w < TMO + 50) begin @(negedge clk); w++; end
    chk(w >= TMO - 4 && w <= TMO + 8, "R10", "timeout latency", w, TMO);
    chk(status_word[6] == 1'b1, "R10", "err flag", status_word[6], 1);
    chk(wcount == 0, "R10", "no writes", wcount, 0);
    chk(unit_busy == 2'b00, "R10", "unit freed", unit_busy, 0);
    chk(longint'(status_time) == ta, "R9", "timeout timestamp", status_time, ta);
    done_block = 1'b0;
    fire(1'b0, 1'b1, 1'b0, ta, ua);
    expect_event(ua, 1'b0, 1'b0, 1'b0, ta);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule